// File: doc/BRIEF.md
# Edge-Capturing General-Purpose I/O Port

This block is a word-addressed general-purpose I/O port of up to 32 pins. A build-time parameter selects one of three variants. The output-only variant drives every pin from a data register. The input variant watches its pins and raises an interrupt. The bidirectional variant sets the direction of each pin from a register, one bit per pin. Software reaches four 32-bit registers through a simple bus with a write strobe, a read strobe and a two-bit word address. Reads return their data one cycle after the strobe, flagged by a valid pulse.

On the input side, every pin passes through a synchronizer chain. A second parameter picks which transitions count as events: rising, falling, or both. Each event sets a sticky bit in the capture register. The bit stays set until software clears it. A single interrupt line is high while any captured bit is also enabled in the mask register. An interrupt handler reads the capture register to learn which pins fired, then writes the capture register to clear it.

Top module: `gpio_edge_port`

## Requirements
- R1: After synchronous reset, all four registers read 0, `irq` is 0, and `pin_out` is 0. In the bidirectional variant `pin_oe` is also 0.
- R2: The word address selects the register: 0 is data, 1 is direction, 2 is interrupt mask, 3 is capture. A read returns on `bus_rdata` with `bus_rvalid` high one cycle after `bus_rd`. Register bits at or above WIDTH read 0, and written data above WIDTH is ignored.
- R3: A data write drives `pin_out` from the next cycle on. A data read returns the pin levels after the synchronizer chain (SYNC_STAGES clocks), except in the output-only variant, where it returns the output register.
- R4: In the bidirectional variant, direction bit 1 makes the pin an output (`pin_oe` bit 1) from the cycle after the write. The output-only variant holds all `pin_oe` bits at 1.
- R5: With EDGE_KIND set to rising, a 0-to-1 transition on a pin sets its capture bit, and a 1-to-0 transition does not.
- R6: With EDGE_KIND set to both, a transition in either direction sets the capture bit.
- R7: A capture bit stays set after the pin returns to its old level, until the capture register is written.
- R8: Any write to the capture register clears every captured bit, whatever the written data.
- R9: An event that reaches the capture register in the same cycle as a clearing write leaves its bit set.
- R10: `irq` is 1 one cycle after some capture bit and its mask bit are both 1. It falls one cycle after the capture is cleared. Captured bits whose mask bit is 0 do not raise it.
- R11: In the output-only variant, the direction, mask and capture registers read 0 even after writes, and `irq` stays 0 while the pins toggle.
- R12: In the input variant, writes to data and direction have no effect: `pin_out` and `pin_oe` stay 0, and the direction register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| pin_in | input | WIDTH | Pin levels, asynchronous |
| pin_out | output | WIDTH | Output pin values |
| pin_oe | output | WIDTH | Output enable, one bit per pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds three copies side by side:
- **8-bit bidirectional, rising edges.** This copy brings the direction register, the masking of captured bits, the ignored falling edge and the race between an event and a clearing write within reach.
- **4-bit input-only, both edges.** This copy shows that falling transitions are captured and that data and direction writes are dropped.
- **6-bit output-only.** This copy shows the upper register bits reading zero, the fixed all-ones output enable, and a silent interrupt while its pins toggle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    PORT_OUT   = 2'd0,
    PORT_IN    = 2'd1,
    PORT_BIDIR = 2'd2
  } port_mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_kind_e;

  // word offsets; software depends on this order
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_DIR  = 2'd1;
  localparam logic [1:0] REG_MASK = 2'd2;
  localparam logic [1:0] REG_CAPT = 2'd3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_port_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned STAGES  = 2,
  parameter edge_kind_e  KIND    = EDGE_RISE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] event_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign level_o = stage_q[STAGES-1];

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign event_o = level_o & ~prev_q;
    end else if (KIND == EDGE_FALL) begin : g_fall
      assign event_o = ~level_o & prev_q;
    end else begin : g_both
      assign event_o = level_o ^ prev_q;
    end
  endgenerate

endmodule

// File: rtl/gpio_capture.sv
module gpio_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] event_i,
  input  logic         clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] capt_o,
  output logic         irq_o
);

  logic [W-1:0] capt_q;
  logic         irq_q;

  // a clearing write drops old bits but keeps any event of the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      capt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      capt_q <= clr_i ? event_i : (capt_q | event_i);
      irq_q  <= |(capt_q & mask_i);
    end
  end

  assign capt_o = capt_q;
  assign irq_o  = irq_q;

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((capt_q & $past(capt_q)) == $past(capt_q)));

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (event_i == '0)) |=> (capt_q == '0));

  // R9
  clear_race_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((capt_q & $past(event_i)) == $past(event_i)));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> ($past(capt_q) != '0));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter port_mode_e  MODE = PORT_BIDIR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic [W-1:0]     out_o,
  output logic [W-1:0]     dir_o,
  output logic [W-1:0]     mask_o,
  output logic             clr_o
);

  logic wr_data_sel, wr_dir_sel, wr_mask_sel;

  assign wr_data_sel = wr_en && (addr == REG_DATA);
  assign wr_dir_sel  = wr_en && (addr == REG_DIR);
  assign wr_mask_sel = wr_en && (addr == REG_MASK);

  generate
    if (MODE != PORT_IN) begin : g_out
      logic [W-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst)              out_q <= '0;
        else if (wr_data_sel) out_q <= wr_data[W-1:0];
      end
      assign out_o = out_q;

      // R3
      data_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_data_sel |=> (out_o == $past(wr_data[W-1:0])));
    end else begin : g_no_out
      assign out_o = '0;
    end

    if (MODE == PORT_BIDIR) begin : g_dir
      logic [W-1:0] dir_q;
      always_ff @(posedge clk) begin
        if (rst)             dir_q <= '0;
        else if (wr_dir_sel) dir_q <= wr_data[W-1:0];
      end
      assign dir_o = dir_q;
    end else begin : g_no_dir
      assign dir_o = '0;
    end

    if (MODE != PORT_OUT) begin : g_mask
      logic [W-1:0] mask_q;
      always_ff @(posedge clk) begin
        if (rst)              mask_q <= '0;
        else if (wr_mask_sel) mask_q <= wr_data[W-1:0];
      end
      assign mask_o = mask_q;
      assign clr_o  = wr_en && (addr == REG_CAPT);
    end else begin : g_no_mask
      assign mask_o = '0;
      assign clr_o  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter port_mode_e  MODE        = PORT_BIDIR,
  parameter edge_kind_e  EDGE_KIND   = EDGE_RISE,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic             irq
);

  logic [WIDTH-1:0] out_w, dir_w, mask_w, level_w, event_w, capt_w;
  logic             clr_w, irq_w;
  logic [WIDTH-1:0] rd_sel;
  logic [BUS_W-1:0] rd_mux, rdata_q;
  logic             rvalid_q;

  gpio_regs #(.W(WIDTH), .MODE(MODE)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wr_data (bus_wdata),
    .out_o   (out_w),
    .dir_o   (dir_w),
    .mask_o  (mask_w),
    .clr_o   (clr_w)
  );

  generate
    if (MODE != PORT_OUT) begin : g_input
      gpio_in_sync #(.W(WIDTH), .STAGES(SYNC_STAGES), .KIND(EDGE_KIND)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pin_in),
        .level_o (level_w),
        .event_o (event_w)
      );
      gpio_capture #(.W(WIDTH)) u_capt (
        .clk     (clk),
        .rst     (rst),
        .event_i (event_w),
        .clr_i   (clr_w),
        .mask_i  (mask_w),
        .capt_o  (capt_w),
        .irq_o   (irq_w)
      );
    end else begin : g_no_input
      assign level_w = out_w;
      assign event_w = '0;
      assign capt_w  = '0;
      assign irq_w   = 1'b0;
    end

    if (MODE == PORT_OUT) begin : g_oe_all
      assign pin_oe = '1;
    end else if (MODE == PORT_IN) begin : g_oe_none
      assign pin_oe = '0;
    end else begin : g_oe_dir
      assign pin_oe = dir_w;

      // R4
      oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == REG_DIR)) |=> (pin_oe == $past(bus_wdata[WIDTH-1:0])));
    end
  endgenerate

  always_comb begin
    case (bus_addr)
      REG_DATA: rd_sel = level_w;
      REG_DIR:  rd_sel = dir_w;
      REG_MASK: rd_sel = mask_w;
      default:  rd_sel = capt_w;
    endcase
    rd_mux = '0;
    rd_mux[WIDTH-1:0] = rd_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign pin_out    = out_w;
  assign irq        = irq_w;

  // R2
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

endmodule

// File: tb/test_gpio_edge_port.sv
`timescale 1ns/1ps
module test_gpio_edge_port;
  import gpio_port_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [1:0]  bus_addr;
  logic [2:0]  bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;

  logic [31:0] rdata_a, rdata_b, rdata_c;
  logic        rvalid_a, rvalid_b, rvalid_c;
  logic [7:0]  pin_a, out_a, oe_a;
  logic [3:0]  pin_b, out_b, oe_b;
  logic [5:0]  pin_c, out_c, oe_c;
  logic        irq_a, irq_b, irq_c;

  gpio_edge_port #(.WIDTH(8), .MODE(PORT_BIDIR), .EDGE_KIND(EDGE_RISE)) i_gpio_edge_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr[0]), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .bus_rvalid(rvalid_a),
    .pin_in(pin_a), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

  gpio_edge_port #(.WIDTH(4), .MODE(PORT_IN), .EDGE_KIND(EDGE_BOTH)) i_gpio_edge_port_in (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr[1]), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .bus_rvalid(rvalid_b),
    .pin_in(pin_b), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

  gpio_edge_port #(.WIDTH(6), .MODE(PORT_OUT), .EDGE_KIND(EDGE_RISE)) i_gpio_edge_port_out (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr[2]), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_c), .bus_rvalid(rvalid_c),
    .pin_in(pin_c), .pin_out(out_c), .pin_oe(oe_c), .irq(irq_c));

  typedef struct {
    int          inst;
    logic [31:0] exp;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (!rst && rvalid_a) begin
      if (sb_q.size() == 0) begin
        check("R2 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        logic [31:0] act;
        e = sb_q.pop_front();
        act = (e.inst == 0) ? rdata_a : (e.inst == 1) ? rdata_b : rdata_c;
        check(e.req, act, e.exp);
      end
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int inst, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 3'b001 << inst;
    @(negedge clk);
    bus_wr    = 3'b000;
  endtask

  task automatic rd(input int inst, input logic [1:0] a, input logic [31:0] e, input string req);
    exp_t item;
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    item.inst = inst;
    item.exp  = e;
    item.req  = req;
    sb_q.push_back(item);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = '0; bus_rd = 1'b0; bus_wdata = '0;
    pin_a = '0; pin_b = '0; pin_c = '0;
    ticks(4);
    rst = 1'b0;
    ticks(1);

    // R1 reset state of the bidirectional copy
    rd(0, REG_DATA, 32'h0, "R1 data after reset");
    rd(0, REG_DIR,  32'h0, "R1 dir after reset");
    rd(0, REG_MASK, 32'h0, "R1 mask after reset");
    rd(0, REG_CAPT, 32'h0, "R1 capt after reset");
    check("R1 irq after reset", {31'd0, irq_a}, 32'd0);
    check("R1 pin_oe after reset", {24'd0, oe_a}, 32'd0);
    check("R1 pin_out after reset", {24'd0, out_a}, 32'd0);

    // R3 data write drives the pins, R2 upper bits dropped
    wr(0, REG_DATA, 32'h0000_00A5);
    check("R3 pin_out after write", {24'd0, out_a}, 32'hA5);
    wr(0, REG_DATA, 32'hFFFF_FF5A);
    check("R2 pin_out upper bits ignored", {24'd0, out_a}, 32'h5A);

    // R4 direction
    wr(0, REG_DIR, 32'h0000_000F);
    check("R4 pin_oe follows direction", {24'd0, oe_a}, 32'h0F);
    rd(0, REG_DIR, 32'h0F, "R2 dir readback");
    wr(0, REG_DIR, 32'hFFFF_FFF0);
    rd(0, REG_DIR, 32'hF0, "R2 dir upper bits read zero");

    // R3 / R5 rising edges captured
    pin_a = 8'h3C;
    ticks(3);
    rd(0, REG_DATA, 32'h3C, "R3 data reads synchronized pins");
    rd(0, REG_CAPT, 32'h3C, "R5 rising edges captured");
    check("R10 irq low with mask 0", {31'd0, irq_a}, 32'd0);

    // R10 mask enables interrupt
    wr(0, REG_MASK, 32'h0000_0004);
    ticks(1);
    check("R10 irq high when masked bit captured", {31'd0, irq_a}, 32'd1);
    rd(0, REG_MASK, 32'h04, "R2 mask readback");

    // R8 write 0 clears, R10 irq falls
    wr(0, REG_CAPT, 32'h0);
    ticks(1);
    check("R10 irq low after clear", {31'd0, irq_a}, 32'd0);
    rd(0, REG_CAPT, 32'h0, "R8 capture cleared by write");

    // R5 falling edges ignored
    pin_a = 8'h00;
    ticks(4);
    rd(0, REG_CAPT, 32'h0, "R5 falling edges ignored");

    // R7 sticky capture
    pin_a = 8'h01;
    ticks(4);
    pin_a = 8'h00;
    ticks(8);
    rd(0, REG_CAPT, 32'h01, "R7 capture bit sticky");
    check("R10 unmasked capture gives no irq", {31'd0, irq_a}, 32'd0);

    // R9 event in the same cycle as the clear stays set; bit 0 is cleared
    pin_a = 8'h02;
    ticks(1);
    wr(0, REG_CAPT, 32'h0);
    rd(0, REG_CAPT, 32'h02, "R9 coinciding event survives clear");

    // R8 writing ones also clears
    pin_a = 8'h00;
    ticks(4);
    wr(0, REG_CAPT, 32'hFFFF_FFFF);
    rd(0, REG_CAPT, 32'h0, "R8 write of ones clears all");

    // input-only copy, both edges
    wr(1, REG_DATA, 32'h0000_000F);
    check("R12 pin_out stays 0", {28'd0, out_b}, 32'd0);
    check("R12 pin_oe stays 0", {28'd0, oe_b}, 32'd0);
    wr(1, REG_DIR, 32'h0000_000F);
    rd(1, REG_DIR, 32'h0, "R12 direction write ignored");
    check("R12 pin_oe still 0", {28'd0, oe_b}, 32'd0);
    pin_b = 4'h5;
    ticks(3);
    rd(1, REG_DATA, 32'h5, "R3 input copy data read");
    rd(1, REG_CAPT, 32'h5, "R6 rising edges captured");
    wr(1, REG_CAPT, 32'h0);
    pin_b = 4'h4;
    ticks(4);
    rd(1, REG_CAPT, 32'h1, "R6 falling edge captured");
    wr(1, REG_MASK, 32'h0000_000F);
    ticks(1);
    check("R10 input copy irq high", {31'd0, irq_b}, 32'd1);
    wr(1, REG_CAPT, 32'h0);
    ticks(1);
    check("R10 input copy irq low after clear", {31'd0, irq_b}, 32'd0);

    // output-only copy
    check("R4 output copy drives all pins", {26'd0, oe_c}, 32'h3F);
    wr(2, REG_DATA, 32'h0000_00EA);
    check("R11 output copy pin_out", {26'd0, out_c}, 32'h2A);
    rd(2, REG_DATA, 32'h2A, "R11 output copy data readback");
    wr(2, REG_MASK, 32'h0000_000F);
    wr(2, REG_DIR,  32'h0000_0001);
    rd(2, REG_MASK, 32'h0, "R11 mask reads 0");
    rd(2, REG_DIR,  32'h0, "R11 dir reads 0");
    pin_c = 6'h3F;
    ticks(4);
    rd(2, REG_CAPT, 32'h0, "R11 capture reads 0");
    check("R11 output copy irq stays 0", {31'd0, irq_c}, 32'd0);

    ticks(2);
    check("R2 all reads returned", sb_q.size(), 32'd0);
    finish_run();
  end

endmodule